// File: doc/BRIEF.md
# Four-Channel DMA Request and Acknowledge Front End

This block sits at the external-request edge of a four-channel DMA controller. Each channel has an active-low request input from a peripheral. The block brings that input into the clock domain and decides whether the channel holds a pending transfer request. It then drives two strobes back to the peripheral. The first is a one-clock accept strobe, which tells the peripheral that its request was taken. The second is an active-low transfer acknowledge, which marks the bus cycle in which the peripheral supplies or receives data.

Three control bits are set per channel. The first picks level or falling-edge detection. The second sets the polarity of the accept strobe. The third places the acknowledge in the read or the write phase of a dual-address transfer. The bus sequencer supplies the rest for each channel: a grant, the addressing mode (single or dual address), a busy flag and the current phase. A mode input picks normal mode or extended mode. In normal mode only the lower two channels obey their control bits. The upper channels act as if every control bit were zero.

Top module: `dma_req_front`

## Requirements
- R1: After reset, `pending` is 0, `ackOutN` is all ones and each `acceptOut` bit sits at its idle level. The request input passes through two synchronising flops: in level mode, a change on `reqInN` shows on `pending` after exactly two rising clock edges.
- R2: With detection bit 0 (level), `pending` is 1 exactly while the synchronised request is low. A request held low therefore stays pending across any number of grants, which gives burst behaviour.
- R3: With detection bit 1 (falling edge), a 1-to-0 transition of the synchronised request sets a stored pending flag. The flag is visible on `pending` three edges after the input falls. It stays set after the request returns high, until an accept is issued.
- R4: In edge mode, the stored flag clears only at the edge that issues an accept. Further edges before that accept give no second accept. An edge seen at the same edge as the accept leaves the flag set.
- R5: The accept strobe is active for exactly the one cycle after an edge at which `grant` and `pending` were both 1. A grant with no pending request gives no strobe.
- R6: Polarity bit 0 makes the accept strobe active-high, with idle 0. Polarity bit 1 makes it active-low, with idle 1.
- R7: In dual-address mode (`singleAddr`=0), `ackOutN` is 0 exactly in the cycles where `busActive` is 1 and `phaseWrite` equals the placement bit. Placement bit 0 selects read (`phaseWrite`=0) and placement bit 1 selects write (`phaseWrite`=1).
- R8: In single-address mode (`singleAddr`=1), `ackOutN` is 0 in every cycle where `busActive` is 1, whatever the phase and the placement bit.
- R9: With `allChanCfg`=0 (normal mode), channels 2 and 3 act as if their detection, polarity and placement bits were all 0. With `allChanCfg`=1, every channel obeys its own bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqInN | input | 4 | Active-low external request per channel |
| detEdge | input | 4 | Detection select per channel: 0 level, 1 falling edge |
| acceptLow | input | 4 | Accept polarity per channel: 0 active-high, 1 active-low |
| ackOnWrite | input | 4 | Acknowledge placement per channel: 0 read phase, 1 write phase |
| allChanCfg | input | 1 | 0 normal mode (upper channels use defaults), 1 all channels configurable |
| singleAddr | input | 4 | Addressing mode per channel: 1 single address, 0 dual address |
| busActive | input | 4 | Sequencer is running a transfer cycle for the channel |
| phaseWrite | input | 4 | Current cycle phase per channel: 0 read, 1 write |
| grant | input | 4 | Sequencer accepts the channel's pending request |
| pending | output | 4 | Channel holds a pending transfer request |
| acceptOut | output | 4 | One-clock accept strobe, polarity per channel |
| ackOutN | output | 4 | Active-low transfer acknowledge |

## Verification
The assertions check on every cycle that the acknowledge is placed correctly. They check that it is held idle when no transfer is running, that it is forced in single-address mode, and that the upper channels use read placement in normal mode. They also check that an accept strobe always follows a grant of a pending request, that the stored edge flag rises only after a synchronised falling edge, and that the flag drops only through an accept. The bench scenarios show the timing that these rules cannot fix alone. This covers the exact two-edge synchroniser delay, burst acceptance while the request stays low, the merging of extra edges before an accept, and an edge that coincides with an accept. It also covers the upper channels switching between default and configured behaviour when the mode input changes.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  // Per-channel strobes handed from the control module to the datapath.
  typedef struct packed {
    logic setFlag;    // store a detected falling edge
    logic clrFlag;    // drop the stored edge
    logic fire;       // issue an accept strobe next cycle
    logic invAccept;  // accept strobe is active-low
    logic ackOn;      // drive the transfer acknowledge this cycle
  } chanStrobe_t;

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CFG_CH = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NCH-1:0]          detEdge,
  input  logic [NCH-1:0]          acceptLow,
  input  logic [NCH-1:0]          ackOnWrite,
  input  logic                    allChanCfg,
  input  logic [NCH-1:0]          singleAddr,
  input  logic [NCH-1:0]          busActive,
  input  logic [NCH-1:0]          phaseWrite,
  input  logic [NCH-1:0]          grant,
  input  logic [NCH-1:0]          reqLow,
  input  logic [NCH-1:0]          reqFall,
  input  logic [NCH-1:0]          edgeFlag,
  output chanStrobe_t [NCH-1:0]   strobes,
  output logic [NCH-1:0]          pending
);

  logic [NCH-1:0] honorVec;
  logic [NCH-1:0] edgeEffVec;
  logic [NCH-1:0] polEffVec;
  logic [NCH-1:0] ackWrEffVec;

  // Lower channels always obey their bits; upper ones only in extended mode.
  for (genvar c = 0; c < NCH; c++) begin : gHonor
    if (c < CFG_CH) begin : gAlways
      assign honorVec[c] = 1'b1;
    end else begin : gByMode
      assign honorVec[c] = allChanCfg;
    end
  end

  assign edgeEffVec  = detEdge    & honorVec;
  assign polEffVec   = acceptLow  & honorVec;
  assign ackWrEffVec = ackOnWrite & honorVec;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      pending[c]           = edgeEffVec[c] ? edgeFlag[c] : reqLow[c];
      strobes[c].fire      = grant[c] & pending[c];
      strobes[c].setFlag   = edgeEffVec[c] & reqFall[c];
      strobes[c].clrFlag   = strobes[c].fire | ~edgeEffVec[c];
      strobes[c].invAccept = polEffVec[c];
      strobes[c].ackOn     = busActive[c] &
                             (singleAddr[c] | (phaseWrite[c] == ackWrEffVec[c]));
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : gChk
    // R3: the stored flag only rises after a synchronised falling edge in edge mode
    a_r3_flag_from_fall: assert property (@(posedge clk) disable iff (!rstN)
      $rose(edgeFlag[c]) |-> $past(reqFall[c] & edgeEffVec[c]));

    // R4: an edge seen in edge mode is never lost
    a_r4_edge_not_lost: assert property (@(posedge clk) disable iff (!rstN)
      $past(edgeEffVec[c] & reqFall[c]) |-> edgeFlag[c]);

    // R4: an edge-mode request only goes away through an accept
    a_r4_drop_by_accept: assert property (@(posedge clk) disable iff (!rstN)
      (edgeEffVec[c] && $past(edgeEffVec[c]) && $fell(pending[c]))
        |-> $past(grant[c] & pending[c]));
  end

endmodule

// File: rtl/dma_req_path.sv
module dma_req_path
  import dma_req_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NCH-1:0]          reqInN,
  input  chanStrobe_t [NCH-1:0]   strobes,
  output logic [NCH-1:0]          reqLow,
  output logic [NCH-1:0]          reqFall,
  output logic [NCH-1:0]          edgeFlag,
  output logic [NCH-1:0]          acceptOut,
  output logic [NCH-1:0]          ackOutN
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [NCH-1:0] acceptQ;

  for (genvar c = 0; c < NCH; c++) begin : gLane
    // Synchroniser stages followed by one extra stage holding the previous sample.
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= '1;
      end else begin
        chain <= {chain[CHAIN_W-2:0], reqInN[c]};
      end
    end

    assign reqLow[c]  = ~chain[SYNC_STAGES-1];
    assign reqFall[c] = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

    // Stored edge: a new edge wins over a clear at the same edge.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeFlag[c] <= 1'b0;
      end else if (strobes[c].setFlag) begin
        edgeFlag[c] <= 1'b1;
      end else if (strobes[c].clrFlag) begin
        edgeFlag[c] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acceptQ[c] <= 1'b0;
      end else begin
        acceptQ[c] <= strobes[c].fire;
      end
    end

    assign acceptOut[c] = acceptQ[c] ^ strobes[c].invAccept;
    assign ackOutN[c]   = ~strobes[c].ackOn;
  end

endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
  import dma_req_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CFG_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] reqInN,
  input  logic [NCH-1:0] detEdge,
  input  logic [NCH-1:0] acceptLow,
  input  logic [NCH-1:0] ackOnWrite,
  input  logic           allChanCfg,
  input  logic [NCH-1:0] singleAddr,
  input  logic [NCH-1:0] busActive,
  input  logic [NCH-1:0] phaseWrite,
  input  logic [NCH-1:0] grant,
  output logic [NCH-1:0] pending,
  output logic [NCH-1:0] acceptOut,
  output logic [NCH-1:0] ackOutN
);

  chanStrobe_t [NCH-1:0] strobes;
  logic [NCH-1:0] reqLow;
  logic [NCH-1:0] reqFall;
  logic [NCH-1:0] edgeFlag;

  dma_req_ctrl #(.NCH(NCH), .CFG_CH(CFG_CH)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .detEdge    (detEdge),
    .acceptLow  (acceptLow),
    .ackOnWrite (ackOnWrite),
    .allChanCfg (allChanCfg),
    .singleAddr (singleAddr),
    .busActive  (busActive),
    .phaseWrite (phaseWrite),
    .grant      (grant),
    .reqLow     (reqLow),
    .reqFall    (reqFall),
    .edgeFlag   (edgeFlag),
    .strobes    (strobes),
    .pending    (pending)
  );

  dma_req_path #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .reqInN    (reqInN),
    .strobes   (strobes),
    .reqLow    (reqLow),
    .reqFall   (reqFall),
    .edgeFlag  (edgeFlag),
    .acceptOut (acceptOut),
    .ackOutN   (ackOutN)
  );

  for (genvar c = 0; c < NCH; c++) begin : gPortChk
    // R7: no acknowledge without a running transfer
    a_r7_ack_idle: assert property (@(posedge clk) disable iff (!rstN)
      !busActive[c] |-> ackOutN[c]);

    // R8: single-address transfers always get the acknowledge
    a_r8_single_ack: assert property (@(posedge clk) disable iff (!rstN)
      (busActive[c] && singleAddr[c]) |-> !ackOutN[c]);

    if (c < CFG_CH) begin : gCfgChan
      // R5: an active accept only follows a granted pending request
      a_r5_accept_after_grant: assert property (@(posedge clk) disable iff (!rstN)
        (acceptOut[c] != acceptLow[c]) |-> $past(grant[c] & pending[c]));

      // R6: without a grant of a pending request the strobe rests at its idle level
      a_r6_idle_level: assert property (@(posedge clk) disable iff (!rstN)
        !$past(grant[c] & pending[c]) |-> (acceptOut[c] == acceptLow[c]));
    end else begin : gDefChan
      // R9: upper channels in normal mode acknowledge in the read phase
      a_r9_default_place: assert property (@(posedge clk) disable iff (!rstN)
        (!allChanCfg && busActive[c] && !singleAddr[c]) |-> (ackOutN[c] == phaseWrite[c]));
    end
  end

endmodule

// File: tb/dma_req_front_test.sv
`timescale 1ns/1ps
module dma_req_front_test;

  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] reqInN = '1;
  logic [NCH-1:0] detEdge = '0;
  logic [NCH-1:0] acceptLow = '0;
  logic [NCH-1:0] ackOnWrite = '0;
  logic allChanCfg = 1'b0;
  logic [NCH-1:0] singleAddr = '0;
  logic [NCH-1:0] busActive = '0;
  logic [NCH-1:0] phaseWrite = '0;
  logic [NCH-1:0] grant = '0;
  logic [NCH-1:0] pending;
  logic [NCH-1:0] acceptOut;
  logic [NCH-1:0] ackOutN;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Reference state built from the requirements
  bit m1 [NCH];
  bit m2 [NCH];
  bit m3 [NCH];
  bit mFlag [NCH];
  bit mAcc [NCH];

  always #10 clk = ~clk;

  dma_req_front uut (
    .clk(clk), .rstN(rstN), .reqInN(reqInN), .detEdge(detEdge),
    .acceptLow(acceptLow), .ackOnWrite(ackOnWrite), .allChanCfg(allChanCfg),
    .singleAddr(singleAddr), .busActive(busActive), .phaseWrite(phaseWrite),
    .grant(grant), .pending(pending), .acceptOut(acceptOut), .ackOutN(ackOutN)
  );

  function automatic bit honorB(int c);
    return (c < 2) || allChanCfg;
  endfunction

  function automatic bit expPend(int c);
    return (detEdge[c] & honorB(c)) ? mFlag[c] : ~m2[c];
  endfunction

  function automatic bit expAccept(int c);
    return mAcc[c] ^ (acceptLow[c] & honorB(c));
  endfunction

  function automatic bit expAckN(int c);
    return ~(busActive[c] & (singleAddr[c] | (phaseWrite[c] == (ackOnWrite[c] & honorB(c)))));
  endfunction

  task automatic chk(input bit got, input bit exp, input string tag, input string what);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compareModel();
    #1;
    for (int c = 0; c < NCH; c++) begin
      chk(pending[c], expPend(c), (detEdge[c] & honorB(c)) ? "R3" : "R2", $sformatf("model pending ch%0d", c));
      chk(acceptOut[c], expAccept(c), "R5", $sformatf("model accept ch%0d", c));
      chk(ackOutN[c], expAckN(c), singleAddr[c] ? "R8" : "R7", $sformatf("model ack ch%0d", c));
    end
  endtask

  task automatic updateModel();
    for (int c = 0; c < NCH; c++) begin
      if (!rstN) begin
        m1[c] = 1; m2[c] = 1; m3[c] = 1; mFlag[c] = 0; mAcc[c] = 0;
      end else begin
        bit edgeMode, fire, fall;
        edgeMode = detEdge[c] & honorB(c);
        fire = grant[c] & expPend(c);
        fall = m3[c] & ~m2[c];
        mFlag[c] = edgeMode ? (fall | (mFlag[c] & ~fire)) : 1'b0;
        mAcc[c] = fire;
        m3[c] = m2[c];
        m2[c] = m1[c];
        m1[c] = reqInN[c];
      end
    end
  endtask

  task automatic step();
    compareModel();
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m1[c] = 1; m2[c] = 1; m3[c] = 1; mFlag[c] = 0; mAcc[c] = 0;
    end
    void'($urandom(32'd20240607));
    @(negedge clk);
    steps(3);
    // R1 reset state
    chk(pending[0] | pending[1] | pending[2] | pending[3], 1'b0, "R1", "pending after reset");
    chk(|acceptOut, 1'b0, "R1", "accept idle after reset");
    chk(&ackOutN, 1'b1, "R1", "ack idle after reset");
    rstN = 1'b1;
    step();

    // R1 two-edge synchroniser delay, R2 level burst
    reqInN[0] = 1'b0;
    step(); chk(pending[0], 1'b0, "R1", "pending one edge after fall");
    step(); chk(pending[0], 1'b1, "R1", "pending two edges after fall");
    steps(3); chk(pending[0], 1'b1, "R2", "level held pending");
    grant[0] = 1'b1;
    step(); chk(acceptOut[0], 1'b1, "R5", "accept after grant");
    step(); chk(acceptOut[0], 1'b1, "R2", "burst accept while held low");
    grant[0] = 1'b0;
    step(); chk(acceptOut[0], 1'b0, "R5", "strobe drops without grant");
    reqInN[0] = 1'b1;
    steps(2); chk(pending[0], 1'b0, "R2", "release clears level pending");
    grant[0] = 1'b1;
    step(); grant[0] = 1'b0;
    chk(acceptOut[0], 1'b0, "R5", "grant without pending gives no strobe");

    // R6 polarity
    acceptLow[0] = 1'b1; settle();
    chk(acceptOut[0], 1'b1, "R6", "active-low idle level");
    reqInN[0] = 1'b0; steps(2);
    grant[0] = 1'b1; step(); grant[0] = 1'b0;
    chk(acceptOut[0], 1'b0, "R6", "active-low strobe");
    step(); chk(acceptOut[0], 1'b1, "R6", "active-low back to idle");
    reqInN[0] = 1'b1; acceptLow[0] = 1'b0; steps(3);

    // R3 edge detection on channel 1
    detEdge[1] = 1'b1;
    reqInN[1] = 1'b0; steps(2);
    chk(pending[1], 1'b0, "R3", "edge not yet stored");
    reqInN[1] = 1'b1; step();
    chk(pending[1], 1'b1, "R3", "edge stored three edges after fall");
    steps(4); chk(pending[1], 1'b1, "R3", "edge held after release");
    // R4 second edge before acceptance merges
    reqInN[1] = 1'b0; step(); reqInN[1] = 1'b1; steps(4);
    chk(pending[1], 1'b1, "R4", "pending after second edge");
    grant[1] = 1'b1; step(); grant[1] = 1'b0;
    chk(acceptOut[1], 1'b1, "R4", "single accept issued");
    chk(pending[1], 1'b0, "R4", "flag cleared by accept");
    steps(3);
    chk(pending[1], 1'b0, "R4", "no double count");
    chk(acceptOut[1], 1'b0, "R4", "no second strobe");
    // R4 edge coinciding with accept is kept
    reqInN[1] = 1'b0; steps(3); reqInN[1] = 1'b1; steps(3);
    reqInN[1] = 1'b0; steps(2);
    grant[1] = 1'b1; step(); grant[1] = 1'b0;
    chk(acceptOut[1], 1'b1, "R4", "accept at coincident edge");
    chk(pending[1], 1'b1, "R4", "coincident edge not lost");
    grant[1] = 1'b1; step(); grant[1] = 1'b0;
    chk(pending[1], 1'b0, "R4", "second accept drains flag");
    reqInN[1] = 1'b1; detEdge[1] = 1'b0; steps(3);

    // R7 dual-address placement
    busActive[0] = 1'b1; singleAddr[0] = 1'b0; phaseWrite[0] = 1'b0; settle();
    chk(ackOutN[0], 1'b0, "R7", "read placement in read phase");
    phaseWrite[0] = 1'b1; settle();
    chk(ackOutN[0], 1'b1, "R7", "read placement in write phase");
    ackOnWrite[0] = 1'b1; settle();
    chk(ackOutN[0], 1'b0, "R7", "write placement in write phase");
    phaseWrite[0] = 1'b0; settle();
    chk(ackOutN[0], 1'b1, "R7", "write placement in read phase");
    busActive[0] = 1'b0; settle();
    chk(ackOutN[0], 1'b1, "R7", "no ack when idle");
    // R8 single-address
    singleAddr[0] = 1'b1; busActive[0] = 1'b1; settle();
    chk(ackOutN[0], 1'b0, "R8", "single addr read phase");
    phaseWrite[0] = 1'b1; ackOnWrite[0] = 1'b0; settle();
    chk(ackOutN[0], 1'b0, "R8", "single addr write phase");
    busActive[0] = 1'b0; singleAddr[0] = 1'b0; phaseWrite[0] = 1'b0; step();

    // R9 upper channel ignores bits in normal mode
    detEdge[2] = 1'b1; acceptLow[2] = 1'b1; ackOnWrite[2] = 1'b1; settle();
    chk(acceptOut[2], 1'b0, "R9", "normal mode default polarity");
    busActive[2] = 1'b1; settle();
    chk(ackOutN[2], 1'b0, "R9", "normal mode default read placement");
    reqInN[2] = 1'b0; steps(2);
    chk(pending[2], 1'b1, "R9", "normal mode level detection");
    reqInN[2] = 1'b1; steps(2);
    chk(pending[2], 1'b0, "R9", "normal mode level release");
    allChanCfg = 1'b1; settle();
    chk(acceptOut[2], 1'b1, "R9", "extended mode polarity honoured");
    chk(ackOutN[2], 1'b1, "R9", "extended mode write placement");
    reqInN[2] = 1'b0; steps(3); reqInN[2] = 1'b1; steps(3);
    chk(pending[2], 1'b1, "R9", "extended mode edge held");
    grant[2] = 1'b1; step(); grant[2] = 1'b0;
    chk(acceptOut[2], 1'b0, "R9", "extended mode active-low strobe");
    step();
    allChanCfg = 1'b0; detEdge[2] = 1'b0; acceptLow[2] = 1'b0; ackOnWrite[2] = 1'b0;
    busActive[2] = 1'b0; steps(3);

    // Constrained random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 50 == 0) begin
        detEdge    = NCH'($urandom);
        acceptLow  = NCH'($urandom);
        ackOnWrite = NCH'($urandom);
        allChanCfg = 1'($urandom);
      end
      for (int c = 0; c < NCH; c++) begin
        if ($urandom % 6 == 0) reqInN[c] = ~reqInN[c];
        grant[c]      = ($urandom % 3 == 0);
        busActive[c]  = 1'($urandom);
        phaseWrite[c] = 1'($urandom);
        singleAddr[c] = ($urandom % 4 == 0);
      end
      step();
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog R5: run incomplete, got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule